// File: doc/BRIEF.md
# Serial Lane Reconfiguration Sequencer

This block moves one serial lane of a multi-lane transceiver to a new protocol and line rate. A request names the lane and the target mode: off, SGMII, 1000BASE-X, HSGMII, 2500BASE-X or 10GBASE-R. The sequencer then runs a fixed series of single-cycle register writes and reads against that lane. It reports the outcome with a one-cycle done pulse that carries an error vector.

Choosing a PLL and confirming that the lane clock is stable are handled by two neighbouring agents. The sequencer reaches each of them through a request/acknowledge handshake. For 10GBASE-R it also checks that the lane front end works, by looping the lane back and pulsing the lane state-machine reset until the latched link indication reports up. All waits are counted in ticks from a prescaler whose divider is an input, so a simulation can use short waits while silicon uses millisecond ones.

Top module: `lane_reconfig_seq`

## Requirements
- R1: For modes other than off and 10GBASE-R, the write series is exactly: power field 3, mode field 0x3F, mode field with the new code, power field 0, RX-reset field 1. The PLL handshake falls between the two mode writes, and the clock handshake falls between the new-mode write and the power-up write.
- R2: The power field (field code 0) is written as 3 to power the lane down and as 0 to power it up. A completed non-off request leaves the lane powered up.
- R3: A mode-field write (field code 1) carries the force-enable flag in data bit 5 and the mode code in bits 4:0. Code 0x1F means off. The other codes are SGMII 0x02, 1000BASE-X 0x04, HSGMII 0x12, 2500BASE-X 0x16 and 10GBASE-R 0x1A. The request mode values are 0 off, 1 SGMII, 2 1000BASE-X, 3 HSGMII, 4 2500BASE-X and 5 10GBASE-R, and values 6 and 7 act as off.
- R4: An off request performs only the power-down write and the mode-off write, then signals done with no error. It makes no PLL or clock request and leaves the lane powered down.
- R5: The PLL request stays high, with its lane and mode held, until it is acknowledged. A fail flag given with the acknowledge sets error bit 0, and the series still continues.
- R6: The clock request stays high until it is acknowledged. A fail flag given with the acknowledge sets error bit 1, and the series still continues.
- R7: For 10GBASE-R, the loopback field (field code 2) is read and saved, then written 1. After the link check it is written back to the saved value.
- R8: A state-machine reset pulse is a write of 1 to field code 3, then a write of 0 after DELAY_TICKS ticks, then a further DELAY_TICKS ticks of waiting. A tick occurs every cfg_tick_div+1 cycles.
- R9: After each reset pulse, the link field (field code 5) is read twice and only the second value is used. Pulses repeat until link is seen, up to MAX_TRIES attempts. If link is never seen, error bit 2 is set. In both cases the loopback is restored and one more reset pulse is issued.
- R10: Done is high for exactly one cycle, with err = {state machine, clock, PLL}. The power-up write and the RX-reset write (field code 4) happen whatever errors were recorded.
- R11: A request that arrives while busy is high is ignored: it causes no writes, no second done pulse and no change of target lane.
- R12: Every write and read of a sequence targets the lane given in the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tick_div | input | DIV_W | Cycles per tick minus one |
| req_valid | input | 1 | Start request, accepted only while idle |
| req_lane | input | LANE_W | Lane to reconfigure |
| req_mode | input | 3 | Target mode value |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | {state machine, clock, PLL} failures, valid with done |
| tgt_lane | output | LANE_W | Lane addressed by writes, reads and handshakes |
| wr_en | output | 1 | Register write strobe |
| wr_field | output | 3 | Field code written |
| wr_data | output | 6 | Write data |
| rd_en | output | 1 | Register read strobe |
| rd_field | output | 3 | Field code read |
| rd_data | input | 1 | Read value, sampled at the edge that ends rd_en |
| pll_req | output | 1 | PLL assignment request |
| pll_mode | output | 3 | Mode for the PLL planner |
| pll_ack | input | 1 | PLL planner acknowledge |
| pll_fail | input | 1 | PLL planner failure, valid with pll_ack |
| clk_req | output | 1 | Clock-ready confirmation request |
| clk_ack | input | 1 | Clock checker acknowledge |
| clk_fail | input | 1 | Clock checker timeout, valid with clk_ack |

## Verification
The assertions assume that the PLL planner and the clock checker each acknowledge with a single-cycle pulse while the matching request is high. They also assume that rd_data is settled at the edge that ends a read strobe. The bench responders raise each acknowledge for one cycle only, a few cycles after they see the request, and drop it before the request could be raised again. The register model presents a read value in the middle of the read cycle. The model clears the link latch only after that value has been presented, so the double read is exercised as a stale read followed by a live read.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [2:0] {
        LM_OFF    = 3'd0,
        LM_SGMII  = 3'd1,
        LM_1GBX   = 3'd2,
        LM_HSGMII = 3'd3,
        LM_2G5BX  = 3'd4,
        LM_10GR   = 3'd5
    } lane_mode_e;

    typedef enum logic [2:0] {
        FLD_POWER = 3'd0,
        FLD_MODE  = 3'd1,
        FLD_LPBK  = 3'd2,
        FLD_SMRST = 3'd3,
        FLD_RXRST = 3'd4,
        FLD_LINK  = 3'd5
    } lane_field_e;

    typedef enum logic [4:0] {
        ST_IDLE, ST_PWR_OFF, ST_MODE_OFF, ST_PLL, ST_MODE_SET, ST_CLK,
        ST_LB_READ, ST_LB_ON, ST_SMR_HI, ST_WAIT_HI, ST_SMR_LO, ST_WAIT_LO,
        ST_LINK_RD1, ST_LINK_RD2, ST_LB_RESTORE, ST_PWR_ON, ST_RX_RST, ST_DONE
    } seq_state_e;

    localparam logic [1:0] PWR_DOWN      = 2'd3;
    localparam logic [1:0] PWR_UP        = 2'd0;
    localparam logic [4:0] MODE_CODE_OFF = 5'h1f;
    localparam int ERR_PLL = 0;
    localparam int ERR_CLK = 1;
    localparam int ERR_SM  = 2;

    function automatic logic [4:0] mode_code(lane_mode_e m);
        case (m)
            LM_SGMII:  return 5'h02;
            LM_1GBX:   return 5'h04;
            LM_HSGMII: return 5'h12;
            LM_2G5BX:  return 5'h16;
            LM_10GR:   return 5'h1a;
            default:   return MODE_CODE_OFF;
        endcase
    endfunction

    function automatic logic [5:0] mode_word(logic [4:0] code);
        return {1'b1, code};
    endfunction

endpackage

// File: rtl/lrs_tick_gen.sv
module lrs_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/lrs_hold_timer.sv
module lrs_hold_timer #(
    parameter int DELAY_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic fire
);
    localparam int DLY_W = $clog2(DELAY_TICKS + 1);

    logic [DLY_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            run  <= 1'b0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (start) begin
                cnt <= '0;
                run <= 1'b1;
            end else if (run && tick) begin
                if (cnt == DLY_W'(DELAY_TICKS - 1)) begin
                    run  <= 1'b0;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R8: the expiry pulse only ever ends a running wait
    p_fire_after_run_r8: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(run));
endmodule

// File: rtl/lane_reconfig_seq.sv
module lane_reconfig_seq
    import lrs_pkg::*;
#(
    parameter int LANE_W      = 3,
    parameter int DIV_W       = 16,
    parameter int DELAY_TICKS = 10,
    parameter int MAX_TRIES   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_tick_div,
    input  logic              req_valid,
    input  logic [LANE_W-1:0] req_lane,
    input  logic [2:0]        req_mode,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err,
    output logic [LANE_W-1:0] tgt_lane,
    output logic              wr_en,
    output logic [2:0]        wr_field,
    output logic [5:0]        wr_data,
    output logic              rd_en,
    output logic [2:0]        rd_field,
    input  logic              rd_data,
    output logic              pll_req,
    output logic [2:0]        pll_mode,
    input  logic              pll_ack,
    input  logic              pll_fail,
    output logic              clk_req,
    input  logic              clk_ack,
    input  logic              clk_fail
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    seq_state_e        state;
    lane_mode_e        mode_q;
    logic [LANE_W-1:0] lane_q;
    logic [2:0]        err_q;
    logic [TRY_W-1:0]  tries;
    logic              lb_saved;
    logic              final_q;
    logic              tick;
    logic              tmr_start;
    logic              tmr_fire;

    lrs_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(cfg_tick_div), .tick(tick)
    );

    assign tmr_start = (state == ST_SMR_HI) || (state == ST_SMR_LO);

    lrs_hold_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
        .clk(clk), .rst(rst), .start(tmr_start), .tick(tick), .fire(tmr_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode_q   <= LM_OFF;
            lane_q   <= '0;
            err_q    <= '0;
            tries    <= '0;
            lb_saved <= 1'b0;
            final_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    lane_q  <= req_lane;
                    mode_q  <= (req_mode > 3'd5) ? LM_OFF : lane_mode_e'(req_mode);
                    err_q   <= '0;
                    tries   <= '0;
                    final_q <= 1'b0;
                    state   <= ST_PWR_OFF;
                end
                ST_PWR_OFF:  state <= ST_MODE_OFF;
                ST_MODE_OFF: state <= (mode_q == LM_OFF) ? ST_DONE : ST_PLL;
                ST_PLL: if (pll_ack) begin
                    err_q[ERR_PLL] <= pll_fail;
                    state          <= ST_MODE_SET;
                end
                ST_MODE_SET: state <= ST_CLK;
                ST_CLK: if (clk_ack) begin
                    err_q[ERR_CLK] <= clk_fail;
                    state          <= (mode_q == LM_10GR) ? ST_LB_READ : ST_PWR_ON;
                end
                ST_LB_READ: begin
                    lb_saved <= rd_data;
                    state    <= ST_LB_ON;
                end
                ST_LB_ON:   state <= ST_SMR_HI;
                ST_SMR_HI:  state <= ST_WAIT_HI;
                ST_WAIT_HI: if (tmr_fire) state <= ST_SMR_LO;
                ST_SMR_LO:  state <= ST_WAIT_LO;
                ST_WAIT_LO: if (tmr_fire) state <= final_q ? ST_PWR_ON : ST_LINK_RD1;
                ST_LINK_RD1: state <= ST_LINK_RD2;
                ST_LINK_RD2: begin
                    tries <= tries + 1'b1;
                    if (rd_data) begin
                        state <= ST_LB_RESTORE;
                    end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
                        err_q[ERR_SM] <= 1'b1;
                        state         <= ST_LB_RESTORE;
                    end else begin
                        state <= ST_SMR_HI;
                    end
                end
                ST_LB_RESTORE: begin
                    final_q <= 1'b1;
                    state   <= ST_SMR_HI;
                end
                ST_PWR_ON: state <= ST_RX_RST;
                ST_RX_RST: state <= ST_DONE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en    = 1'b0;
        wr_field = FLD_POWER;
        wr_data  = '0;
        rd_en    = 1'b0;
        rd_field = FLD_LINK;
        case (state)
            ST_PWR_OFF:    begin wr_en = 1'b1; wr_field = FLD_POWER; wr_data = {4'd0, PWR_DOWN}; end
            ST_MODE_OFF:   begin wr_en = 1'b1; wr_field = FLD_MODE;  wr_data = mode_word(MODE_CODE_OFF); end
            ST_MODE_SET:   begin wr_en = 1'b1; wr_field = FLD_MODE;  wr_data = mode_word(mode_code(mode_q)); end
            ST_LB_ON:      begin wr_en = 1'b1; wr_field = FLD_LPBK;  wr_data = 6'd1; end
            ST_SMR_HI:     begin wr_en = 1'b1; wr_field = FLD_SMRST; wr_data = 6'd1; end
            ST_SMR_LO:     begin wr_en = 1'b1; wr_field = FLD_SMRST; wr_data = 6'd0; end
            ST_LB_RESTORE: begin wr_en = 1'b1; wr_field = FLD_LPBK;  wr_data = {5'd0, lb_saved}; end
            ST_PWR_ON:     begin wr_en = 1'b1; wr_field = FLD_POWER; wr_data = {4'd0, PWR_UP}; end
            ST_RX_RST:     begin wr_en = 1'b1; wr_field = FLD_RXRST; wr_data = 6'd1; end
            ST_LB_READ:    begin rd_en = 1'b1; rd_field = FLD_LPBK; end
            ST_LINK_RD1,
            ST_LINK_RD2:   begin rd_en = 1'b1; rd_field = FLD_LINK; end
            default: ;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
    assign err      = err_q;
    assign tgt_lane = lane_q;
    assign pll_req  = (state == ST_PLL);
    assign pll_mode = mode_q;
    assign clk_req  = (state == ST_CLK);

    // R5: an unanswered PLL request is held with stable lane and mode
    p_pll_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (pll_req && !pll_ack) |=> (pll_req && $stable(pll_mode) && $stable(tgt_lane)));
    // R6: an unanswered clock request is held
    p_clk_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (clk_req && !clk_ack) |=> clk_req);
    // R10: done lasts one cycle and returns the block to idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
    // R11: a request seen mid-sequence does not retarget the lane
    p_refuse_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && req_valid) |=> $stable(tgt_lane));
    // R1: at most one lane access or handshake is active per cycle
    p_one_action_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, rd_en, pll_req, clk_req}));
    // R9: the attempt count never exceeds its limit
    p_tries_bound_r9: assert property (@(posedge clk) disable iff (rst)
        tries <= TRY_W'(MAX_TRIES));
endmodule

// File: tb/lane_reconfig_seq_bench.sv
module lane_reconfig_seq_bench;
    localparam int LANE_W = 3;
    localparam int DIV_W  = 16;
    localparam int DLY    = 10;
    localparam int TRIES  = 20;
    localparam int DIV    = 3;
    localparam int NEVER  = 99;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DIV_W-1:0]  cfg_tick_div = DIV_W'(DIV);
    logic              req_valid = 1'b0;
    logic [LANE_W-1:0] req_lane = '0;
    logic [2:0]        req_mode = '0;
    logic              busy, done, wr_en, rd_en, pll_req, clk_req;
    logic [2:0]        err, wr_field, rd_field, pll_mode;
    logic [5:0]        wr_data;
    logic [LANE_W-1:0] tgt_lane;
    logic              rd_data = 1'b0;
    logic              pll_ack = 1'b0, pll_fail = 1'b0;
    logic              clk_ack = 1'b0, clk_fail = 1'b0;

    always #5 clk = ~clk;

    lane_reconfig_seq #(.LANE_W(LANE_W), .DIV_W(DIV_W), .DELAY_TICKS(DLY), .MAX_TRIES(TRIES))
    u_lane_reconfig_seq (
        .clk(clk), .rst(rst), .cfg_tick_div(cfg_tick_div),
        .req_valid(req_valid), .req_lane(req_lane), .req_mode(req_mode),
        .busy(busy), .done(done), .err(err), .tgt_lane(tgt_lane),
        .wr_en(wr_en), .wr_field(wr_field), .wr_data(wr_data),
        .rd_en(rd_en), .rd_field(rd_field), .rd_data(rd_data),
        .pll_req(pll_req), .pll_mode(pll_mode), .pll_ack(pll_ack), .pll_fail(pll_fail),
        .clk_req(clk_req), .clk_ack(clk_ack), .clk_fail(clk_fail)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // lane register model and logs
    logic [1:0] pwr_m [0:7];
    logic       lb_m  [0:7];
    int         smr_count;
    bit         link_latch_low;
    int         link_after;
    logic [8:0] log_ent [0:255];
    int         log_cyc [0:255];
    logic [LANE_W-1:0] log_lane [0:255];
    int         n_log;
    logic [8:0] exp_ent [0:255];
    int         n_exp;
    int         cyc;
    int         done_cnt;
    logic [2:0] err_cap;
    bit         cfg_pf, cfg_cf;
    int         pll_wait, clk_wait, pll_cnt, clk_cnt;
    logic [2:0] pll_mode_seen;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // single monitor and responder process at the falling edge
    initial begin
        pll_wait = 3; clk_wait = 4;
        forever begin
            @(negedge clk);
            cyc++;
            if (wr_en && n_log < 256) begin
                log_ent[n_log]  = {wr_field, wr_data};
                log_cyc[n_log]  = cyc;
                log_lane[n_log] = tgt_lane;
                n_log++;
                if (wr_field == 3'd0) pwr_m[tgt_lane] = wr_data[1:0];
                if (wr_field == 3'd2) lb_m[tgt_lane]  = wr_data[0];
                if (wr_field == 3'd3 && wr_data[0]) begin
                    smr_count++;
                    link_latch_low = 1'b1;
                end
            end
            if (rd_en) begin
                if (rd_field == 3'd2) rd_data = lb_m[tgt_lane];
                else if (link_latch_low) begin
                    rd_data = 1'b0;
                    link_latch_low = 1'b0;
                end else rd_data = (smr_count >= link_after);
            end
            if (done) begin
                done_cnt++;
                err_cap = err;
            end
            if (pll_ack) begin
                pll_ack = 1'b0; pll_fail = 1'b0;
            end else if (pll_req) begin
                if (pll_wait == 0) begin
                    pll_ack = 1'b1; pll_fail = cfg_pf; pll_wait = 3;
                    pll_cnt++; pll_mode_seen = pll_mode;
                end else pll_wait--;
            end
            if (clk_ack) begin
                clk_ack = 1'b0; clk_fail = 1'b0;
            end else if (clk_req) begin
                if (clk_wait == 0) begin
                    clk_ack = 1'b1; clk_fail = cfg_cf; clk_wait = 4; clk_cnt++;
                end else clk_wait--;
            end
        end
    end

    function automatic logic [4:0] exp_code(input logic [2:0] m);
        case (m)
            3'd1: return 5'h02;
            3'd2: return 5'h04;
            3'd3: return 5'h12;
            3'd4: return 5'h16;
            3'd5: return 5'h1a;
            default: return 5'h1f;
        endcase
    endfunction

    task automatic push(input logic [2:0] f, input logic [5:0] d);
        exp_ent[n_exp] = {f, d};
        n_exp++;
    endtask

    task automatic clear_logs();
        n_log = 0; n_exp = 0; done_cnt = 0; err_cap = '0;
        smr_count = 0; link_latch_low = 1'b0; pll_cnt = 0; clk_cnt = 0;
    endtask

    task automatic issue(input logic [2:0] m, input logic [LANE_W-1:0] ln);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_lane = ln;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done_cnt == 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic compare_log(input string req);
        int first_bad = -1;
        bit lane_ok = 1'b1;
        for (int i = 0; i < n_exp && i < n_log; i++)
            if (first_bad < 0 && log_ent[i] !== exp_ent[i]) first_bad = i;
        chk(n_log == n_exp, req, "write count", n_log, n_exp);
        chk(first_bad < 0, req, "write series entry",
            (first_bad < 0) ? 0 : int'(log_ent[first_bad]),
            (first_bad < 0) ? 0 : int'(exp_ent[first_bad]));
        for (int i = 0; i < n_log; i++)
            if (log_lane[i] !== req_lane) lane_ok = 1'b0;
        chk(lane_ok, "R12", "write lane", int'(req_lane), int'(req_lane));
    endtask

    // full sequence with model setup and expected-value computation
    task automatic run_seq(input logic [2:0] m, input logic [LANE_W-1:0] ln, input bit pf,
                           input bit cf, input int la, input bit lb_init, input string req);
        int k;
        bit is_off;
        bit sm_fail;
        clear_logs();
        cfg_pf = pf; cfg_cf = cf; link_after = la;
        lb_m[ln] = lb_init;
        issue(m, ln);
        wait_done();
        is_off  = (m == 3'd0) || (m > 3'd5);
        k       = (la >= 1 && la <= TRIES) ? la : TRIES;
        sm_fail = (m == 3'd5) && !(la >= 1 && la <= TRIES);
        push(3'd0, 6'd3);
        push(3'd1, 6'h3f);
        if (!is_off) begin
            push(3'd1, {1'b1, exp_code(m)});
            if (m == 3'd5) begin
                push(3'd2, 6'd1);
                for (int i = 0; i < k; i++) begin
                    push(3'd3, 6'd1); push(3'd3, 6'd0);
                end
                push(3'd2, {5'd0, lb_init});
                push(3'd3, 6'd1); push(3'd3, 6'd0);
            end
            push(3'd0, 6'd0);
            push(3'd4, 6'd1);
        end
        compare_log(req);
        chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
        chk(err_cap == (is_off ? 3'b000 : {sm_fail, cf, pf}), "R10", "error vector",
            int'(err_cap), is_off ? 0 : int'({sm_fail, cf, pf}));
        if (is_off) begin
            chk(pll_cnt == 0 && clk_cnt == 0, "R4", "handshakes on off request", pll_cnt + clk_cnt, 0);
            chk(pwr_m[ln] == 2'd3, "R4", "final power field", int'(pwr_m[ln]), 3);
        end else begin
            chk(pwr_m[ln] == 2'd0, "R2", "final power field", int'(pwr_m[ln]), 0);
            chk(pll_cnt == 1 && pll_mode_seen == m, "R5", "PLL request mode", int'(pll_mode_seen), int'(m));
            chk(lb_m[ln] == lb_init, "R7", "loopback after sequence", int'(lb_m[ln]), int'(lb_init));
        end
        if (m == 3'd5) begin
            bit gap_ok = 1'b1;
            int bad_gap = 0;
            for (int i = 0; i + 1 < n_log; i++)
                if (log_ent[i] == {3'd3, 6'd1} && log_ent[i+1] == {3'd3, 6'd0}) begin
                    int g = log_cyc[i+1] - log_cyc[i];
                    if (g < (DLY - 1) * (DIV + 1) || g > DLY * (DIV + 1) + 3) begin
                        gap_ok = 1'b0; bad_gap = g;
                    end
                end
            chk(gap_ok, "R8", "reset pulse width in cycles", bad_gap, DLY * (DIV + 1));
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !wr_en && !rd_en && !pll_req && !clk_req, "R10",
            "idle outputs after reset", int'({busy, done, wr_en, rd_en, pll_req, clk_req}), 0);
    endtask

    task automatic t_sgmii();   run_seq(3'd1, 3'd2, 1'b0, 1'b0, NEVER, 1'b0, "R1"); endtask
    task automatic t_1gbx();    run_seq(3'd2, 3'd6, 1'b0, 1'b0, NEVER, 1'b0, "R3"); endtask
    task automatic t_off();     run_seq(3'd0, 3'd5, 1'b0, 1'b0, NEVER, 1'b0, "R4"); endtask
    task automatic t_mode7();   run_seq(3'd7, 3'd4, 1'b0, 1'b0, NEVER, 1'b0, "R3"); endtask
    task automatic t_2g5_err(); run_seq(3'd4, 3'd3, 1'b1, 1'b1, NEVER, 1'b0, "R6"); endtask
    task automatic t_hsgmii();  run_seq(3'd3, 3'd0, 1'b1, 1'b0, NEVER, 1'b0, "R5"); endtask
    task automatic t_10g_fast();run_seq(3'd5, 3'd1, 1'b0, 1'b0, 1,     1'b0, "R7"); endtask
    task automatic t_10g_retry();run_seq(3'd5, 3'd7, 1'b0, 1'b0, 3,    1'b1, "R9"); endtask
    task automatic t_10g_never();run_seq(3'd5, 3'd2, 1'b0, 1'b0, NEVER, 1'b1, "R9"); endtask

    task automatic t_busy();
        int writes_at_done;
        clear_logs();
        cfg_pf = 1'b0; cfg_cf = 1'b0; link_after = NEVER;
        issue(3'd1, 3'd1);
        repeat (3) @(negedge clk);
        chk(busy, "R11", "busy during sequence", int'(busy), 1);
        req_valid = 1'b1; req_mode = 3'd5; req_lane = 3'd3;
        @(negedge clk);
        req_valid = 1'b0; req_lane = 3'd1;
        wait_done();
        writes_at_done = n_log;
        repeat (40) @(negedge clk);
        chk(done_cnt == 1, "R11", "done pulses with refused request", done_cnt, 1);
        chk(n_log == writes_at_done && n_log == 5, "R11", "writes with refused request", n_log, 5);
        chk(!busy, "R11", "idle after refused request", int'(busy), 0);
        n_exp = 0;
        push(3'd0, 6'd3); push(3'd1, 6'h3f); push(3'd1, {1'b1, 5'h02});
        push(3'd0, 6'd0); push(3'd4, 6'd1);
        compare_log("R11");
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            pwr_m[i] = 2'd0; lb_m[i] = 1'b0;
        end
        cyc = 0;
        clear_logs();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sgmii();
        t_1gbx();
        t_off();
        t_mode7();
        t_2g5_err();
        t_hsgmii();
        t_10g_fast();
        t_10g_retry();
        t_10g_never();
        t_busy();
        summary();
    end
endmodule